// File: doc/BRIEF.md
# FIFO Trigger Level Request Generator

This block produces two request lines for a serial port's data FIFOs, each 64 entries deep. The receive request asks for service once enough characters have built up in the receive FIFO. The transmit request asks for data once enough free slots have opened in the transmit FIFO. Both requests can feed interrupt logic or DMA logic. The FIFOs, the interrupt priority logic and the DMA handshake sit outside the block and supply the two occupancy counts.

Each direction takes its threshold from one of two places. The first is a 2-bit default-level code in the FIFO control register. The second is a nibble in an 8-bit programmable level register; when the nibble is nonzero, it replaces the default with four times its value. Software writes the level register through a simple write strobe. A write takes effect only while two enable bits are both set.

Top module: `fifo_trig_req`

## Requirements
- R1: While rst_ni is low, both rx_req_o and tx_req_o are 0 and the level register is cleared to 0x00, so after reset both directions use their default levels.
- R2: A write with cfg_we_i=1 loads cfg_wdata_i into the level register on the next clock edge only when ext_feat_en_i=1 and latch_sel_i=1; otherwise the register keeps its value.
- R3: When level register bits 7:4 are nonzero, the receive threshold is that nibble times 4 (nibble 1 gives 4, nibble 15 gives 60).
- R4: When level register bits 3:0 are nonzero, the transmit threshold is that nibble times 4, counted in free spaces.
- R5: When bits 7:4 are zero, rx_sel_i selects the receive threshold: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 56 and 2'b11 gives 60 characters.
- R6: When bits 3:0 are zero, tx_sel_i selects the transmit threshold: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 56 free spaces.
- R7: rx_req_o is 1 one clock after rx_count_i >= the receive threshold.
- R8: tx_req_o is 1 one clock after 64 - tx_count_i >= the transmit threshold.
- R9: Each request returns to 0 on the clock edge that follows the cycle in which its condition became false.
- R10: Each nibble is decoded on its own. A zero nibble in one direction selects that direction's default while the other direction's nonzero nibble still overrides its own default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the level register |
| cfg_wdata_i | input | 8 | Write data; bits 7:4 set the receive level, bits 3:0 set the transmit level |
| ext_feat_en_i | input | 1 | Write unlock bit from the extended feature register |
| latch_sel_i | input | 1 | Write unlock bit from the modem control register |
| rx_sel_i | input | 2 | Default receive level code |
| tx_sel_i | input | 2 | Default transmit level code |
| rx_count_i | input | 7 | Characters held in the receive FIFO (0..64) |
| tx_count_i | input | 7 | Characters held in the transmit FIFO (0..64) |
| rx_req_o | output | 1 | Receive-ready request |
| tx_req_o | output | 1 | Transmit-ready request |

## Verification
A register write and a threshold comparison can fall in the same cycle: the count moves across the new threshold in the same cycle that a write changes that threshold. The bench provokes this by raising the write strobe at the same clock edge that drives the count to a value that lies between the old threshold and the new one. It then expects the request after the first edge to follow the old threshold and the request after the second edge to follow the new one. Each expected value comes from the levels stated in the requirements, not from the design.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;

  localparam int unsigned FIFO_DEPTH = 64;
  localparam int unsigned LVL_STEP   = 4;

  typedef enum logic [1:0] {
    DSEL_0 = 2'b00,
    DSEL_1 = 2'b01,
    DSEL_2 = 2'b10,
    DSEL_3 = 2'b11
  } dflt_sel_e;

  function automatic int unsigned rx_default(input dflt_sel_e sel);
    case (sel)
      DSEL_0:  return 8;
      DSEL_1:  return 16;
      DSEL_2:  return 56;
      default: return 60;
    endcase
  endfunction

  function automatic int unsigned tx_default(input dflt_sel_e sel);
    case (sel)
      DSEL_0:  return 8;
      DSEL_1:  return 16;
      DSEL_2:  return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/trig_lvl_reg.sv
module trig_lvl_reg #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned RW   = 2 * NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RW-1:0]    wdata_i,
  input  logic             unlock_a_i,
  input  logic             unlock_b_i,
  output logic [NIB_W-1:0] rx_nib_o,
  output logic [NIB_W-1:0] tx_nib_o
);

  logic [RW-1:0] lvl_q;
  logic          wr_ok;

  assign wr_ok = we_i & unlock_a_i & unlock_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lvl_q <= '0;
    else if (wr_ok) lvl_q <= wdata_i;
  end

  assign rx_nib_o = lvl_q[RW-1:NIB_W];
  assign tx_nib_o = lvl_q[NIB_W-1:0];

  // R2
  wr_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && unlock_a_i && unlock_b_i) |=> $stable({rx_nib_o, tx_nib_o}));

  // R2
  wr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && unlock_a_i && unlock_b_i) |=> ({rx_nib_o, tx_nib_o} == $past(wdata_i)));

endmodule

// File: rtl/trig_lvl_sel.sv
module trig_lvl_sel
  import fifo_trig_pkg::*;
#(
  parameter bit          IS_TX = 1'b0,
  parameter int unsigned NIB_W = 4,
  parameter int unsigned STEP  = LVL_STEP,
  parameter int unsigned LW    = 7
) (
  input  logic [NIB_W-1:0] nib_i,
  input  logic [1:0]       sel_i,
  output logic [LW-1:0]    lvl_o
);

  logic [LW-1:0] dflt_lvl;
  logic [LW-1:0] prog_lvl;

  generate
    if (IS_TX) begin : g_tx
      assign dflt_lvl = LW'(tx_default(dflt_sel_e'(sel_i)));
    end else begin : g_rx
      assign dflt_lvl = LW'(rx_default(dflt_sel_e'(sel_i)));
    end
  endgenerate

  assign prog_lvl = LW'(nib_i) * LW'(STEP);

  // zero nibble falls back to the coded default
  assign lvl_o = (nib_i != '0) ? prog_lvl : dflt_lvl;

endmodule

// File: rtl/trig_req_cmp.sv
module trig_req_cmp #(
  parameter int unsigned DEPTH      = 64,
  parameter bit          COUNT_FREE = 1'b0,
  parameter int unsigned CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] lvl_i,
  output logic          req_o
);

  logic [CW-1:0] metric;
  logic          hit;
  logic          req_q;

  generate
    if (COUNT_FREE) begin : g_free
      assign metric = CW'(DEPTH) - count_i;
    end else begin : g_used
      assign metric = count_i;
    end
  endgenerate

  assign hit = (metric >= lvl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= hit;
  end

  assign req_o = req_q;

  // R7 R8
  req_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (metric >= lvl_i) |=> req_o);

  // R9
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && (metric < lvl_i)) |=> !req_o);

  // R3 R4 R5 R6
  lvl_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i != '0) && (lvl_i <= CW'(DEPTH)) && (lvl_i[1:0] == 2'b00));

endmodule

// File: rtl/fifo_trig_req.sv
module fifo_trig_req
  import fifo_trig_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  parameter int unsigned NIB_W = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned RW   = 2 * NIB_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [RW-1:0] cfg_wdata_i,
  input  logic          ext_feat_en_i,
  input  logic          latch_sel_i,
  input  logic [1:0]    rx_sel_i,
  input  logic [1:0]    tx_sel_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic [CW-1:0] tx_count_i,
  output logic          rx_req_o,
  output logic          tx_req_o
);

  logic [NIB_W-1:0] rx_nib, tx_nib;
  logic [CW-1:0]    rx_lvl, tx_lvl;

  trig_lvl_reg #(.NIB_W(NIB_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .unlock_a_i (ext_feat_en_i),
    .unlock_b_i (latch_sel_i),
    .rx_nib_o   (rx_nib),
    .tx_nib_o   (tx_nib)
  );

  trig_lvl_sel #(.IS_TX(1'b0), .NIB_W(NIB_W), .LW(CW)) u_rx_sel (
    .nib_i (rx_nib),
    .sel_i (rx_sel_i),
    .lvl_o (rx_lvl)
  );

  trig_lvl_sel #(.IS_TX(1'b1), .NIB_W(NIB_W), .LW(CW)) u_tx_sel (
    .nib_i (tx_nib),
    .sel_i (tx_sel_i),
    .lvl_o (tx_lvl)
  );

  trig_req_cmp #(.DEPTH(DEPTH), .COUNT_FREE(1'b0), .CW(CW)) u_rx_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (rx_count_i),
    .lvl_i   (rx_lvl),
    .req_o   (rx_req_o)
  );

  trig_req_cmp #(.DEPTH(DEPTH), .COUNT_FREE(1'b1), .CW(CW)) u_tx_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (tx_count_i),
    .lvl_i   (tx_lvl),
    .req_o   (tx_req_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!rx_req_o && !tx_req_o));

endmodule

// File: tb/fifo_trig_req_tb.sv
`timescale 1ns/1ps
module fifo_trig_req_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cfg_we_i;
  logic [7:0] cfg_wdata_i;
  logic       ext_feat_en_i;
  logic       latch_sel_i;
  logic [1:0] rx_sel_i;
  logic [1:0] tx_sel_i;
  logic [6:0] rx_count_i;
  logic [6:0] tx_count_i;
  logic       rx_req_o;
  logic       tx_req_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  fifo_trig_req u_dut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .ext_feat_en_i, .latch_sel_i,
    .rx_sel_i, .tx_sel_i, .rx_count_i, .tx_count_i, .rx_req_o, .tx_req_o
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic write_lvl(input logic [7:0] d, input logic ea, input logic eb);
    cfg_we_i = 1'b1; cfg_wdata_i = d; ext_feat_en_i = ea; latch_sel_i = eb;
    @(negedge clk_i);
    cfg_we_i = 1'b0; ext_feat_en_i = 1'b0; latch_sel_i = 1'b0;
  endtask

  task automatic rx_thr(input int lvl, input string req);
    rx_count_i = 7'(lvl - 1);
    @(negedge clk_i);
    check(rx_req_o, 1'b0, req, $sformatf("rx below %0d", lvl));
    rx_count_i = 7'(lvl);
    @(negedge clk_i);
    check(rx_req_o, 1'b1, req, $sformatf("rx at %0d", lvl));
  endtask

  task automatic tx_thr(input int lvl, input string req);
    tx_count_i = 7'(64 - lvl + 1);
    @(negedge clk_i);
    check(tx_req_o, 1'b0, req, $sformatf("tx free below %0d", lvl));
    tx_count_i = 7'(64 - lvl);
    @(negedge clk_i);
    check(tx_req_o, 1'b1, req, $sformatf("tx free at %0d", lvl));
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; cfg_we_i = 1'b0; cfg_wdata_i = '0;
    ext_feat_en_i = 1'b0; latch_sel_i = 1'b0;
    rx_sel_i = 2'b00; tx_sel_i = 2'b00;
    rx_count_i = 7'd64; tx_count_i = 7'd0;
    repeat (3) @(negedge clk_i);
    check(rx_req_o, 1'b0, "R1", "rx in reset");
    check(tx_req_o, 1'b0, "R1", "tx in reset");
    rst_ni = 1'b1;
    rx_thr(8, "R1");
    tx_thr(8, "R1");
  endtask

  task automatic t_rx_default();
    int tbl[4] = '{8, 16, 56, 60};
    for (int s = 0; s < 4; s++) begin
      rx_sel_i = 2'(s);
      rx_thr(tbl[s], "R5");
    end
    rx_sel_i = 2'b00;
  endtask

  task automatic t_tx_default();
    int tbl[4] = '{8, 16, 32, 56};
    for (int s = 0; s < 4; s++) begin
      tx_sel_i = 2'(s);
      tx_thr(tbl[s], "R6");
    end
    tx_sel_i = 2'b00;
  endtask

  task automatic t_prog();
    write_lvl(8'h53, 1'b1, 1'b1);
    rx_thr(20, "R3");
    tx_thr(12, "R4");
    write_lvl(8'hF1, 1'b1, 1'b1);
    rx_thr(60, "R3");
    tx_thr(4, "R4");
    write_lvl(8'h1F, 1'b1, 1'b1);
    rx_thr(4, "R3");
    tx_thr(60, "R4");
  endtask

  task automatic t_lock();
    write_lvl(8'h22, 1'b1, 1'b1);
    write_lvl(8'h99, 1'b0, 1'b1);
    rx_thr(8, "R2");
    tx_thr(8, "R2");
    write_lvl(8'h99, 1'b1, 1'b0);
    rx_thr(8, "R2");
    tx_thr(8, "R2");
    write_lvl(8'h99, 1'b1, 1'b1);
    rx_thr(36, "R2");
  endtask

  task automatic t_mixed();
    rx_sel_i = 2'b10; tx_sel_i = 2'b10;
    write_lvl(8'h30, 1'b1, 1'b1);
    rx_thr(12, "R10");
    tx_thr(32, "R10");
    write_lvl(8'h07, 1'b1, 1'b1);
    rx_thr(56, "R10");
    tx_thr(28, "R10");
    rx_sel_i = 2'b00; tx_sel_i = 2'b00;
  endtask

  task automatic t_deassert();
    write_lvl(8'h00, 1'b1, 1'b1);
    rx_count_i = 7'd8; tx_count_i = 7'd56;
    @(negedge clk_i);
    check(rx_req_o, 1'b1, "R7", "rx set");
    check(tx_req_o, 1'b1, "R8", "tx set");
    rx_count_i = 7'd7; tx_count_i = 7'd57;
    #1;
    check(rx_req_o, 1'b1, "R9", "rx held before edge");
    @(negedge clk_i);
    check(rx_req_o, 1'b0, "R9", "rx cleared after edge");
    check(tx_req_o, 1'b0, "R9", "tx cleared after edge");
  endtask

  task automatic t_same_cycle();
    // level 8 default -> write 0x44 makes both 16; count sits at 12
    rx_count_i = 7'd12; tx_count_i = 7'd52;
    cfg_we_i = 1'b1; cfg_wdata_i = 8'h44; ext_feat_en_i = 1'b1; latch_sel_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0; ext_feat_en_i = 1'b0; latch_sel_i = 1'b0;
    check(rx_req_o, 1'b1, "R7", "rx old level in write cycle");
    check(tx_req_o, 1'b1, "R8", "tx old level in write cycle");
    @(negedge clk_i);
    check(rx_req_o, 1'b0, "R3", "rx new level after write");
    check(tx_req_o, 1'b0, "R4", "tx new level after write");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rx_default();
    t_tx_default();
    t_prog();
    t_lock();
    t_mixed();
    t_deassert();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule